// File: doc/BRIEF.md
# Hub-Execution Instruction Cache

This block sits between a processor core's fetch stage and two code stores: a small local register RAM and a large shared hub memory. The core presents a 16-bit long-word program counter with a fetch request. The value of the address alone decides where the fetch goes. Addresses up to 0x01FF are read from the local RAM. Anything higher is looked up in a four-line, read-only cache whose lines each hold eight 32-bit longs. Because the path follows from the address, the design stores no execution-mode flag.

A lookup that hits returns the instruction one cycle after the request. This is the same latency as a local-RAM read, so code held in the cache runs at full speed. A miss asks the hub for an eight-long burst that starts at the line's base address and writes the burst into a victim line. When the last long has arrived, the tag is committed and the requested instruction is returned. While a fill is in progress the block reports that it is busy, and it ignores any new fetch. Lines are replaced by true least-recently-used order, and an empty line is always chosen before a valid one.

Top module: `hubexec_icache`

## Requirements
- R1: A request with `fetch_pc` <= 0x01FF and `busy` low asserts `local_rd_en` in that cycle, with `local_addr` = `fetch_pc[8:0]`. In the next cycle `insn_valid` is 1 and `insn_data` equals the `local_rdata` that the RAM returns for that address. The hub is not touched.
- R2: A request with `fetch_pc` > 0x01FF that misses raises `busy` and `hub_req` from the next cycle. `hub_addr` is held at `fetch_pc` with bits [2:0] cleared until the burst ends.
- R3: Each cycle in which `hub_rvalid` is high during a fill writes one long, in offset order 0 to 7. Pulses of `hub_rvalid` while `busy` is low are ignored. On the cycle after the eighth long, `busy` and `hub_req` are low and `insn_valid` delivers the long at `fetch_pc[2:0]` of the missing request.
- R4: A request with `fetch_pc` > 0x01FF that hits a valid line gives `insn_valid` with the cached long in the next cycle, and it makes no hub request.
- R5: While `busy` is high, `fetch_req` is ignored. No local read, no lookup, no replacement-order update and no output follow from it.
- R6: After reset, `insn_valid`, `hub_req` and `busy` are 0 and no line is valid, so the first cached fetch misses.
- R7: There are four lines. A miss fills the lowest-numbered invalid line, or else the least recently used line. Both a hit and a completed fill make the line concerned the most recently used.
- R8: There is no stored mode. Back-to-back requests can switch between local and cached addresses on any cycle, and each is routed by its own address.
- R9: The line tag is `fetch_pc[15:3]`. Two addresses that differ only in bits [2:0] share a line, so the second one hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request from the core |
| fetch_pc | input | 16 | Long-word program counter of the fetch |
| busy | output | 1 | Line fill in progress; requests ignored |
| local_rd_en | output | 1 | Read strobe to local register RAM |
| local_addr | output | 9 | Local RAM address |
| local_rdata | input | 32 | Local RAM data, one cycle after the strobe |
| insn_valid | output | 1 | Instruction output valid |
| insn_data | output | 32 | Instruction word (0 when not valid) |
| hub_req | output | 1 | Burst request, held for the whole fill |
| hub_addr | output | 16 | Line base long address of the burst |
| hub_rvalid | input | 1 | One burst long present on hub_rdata |
| hub_rdata | input | 32 | Burst data from the hub |

## Verification
Two events can collide in one cycle. The eighth burst long can arrive in the same cycle that the tag commits and the requested word is chosen, which is the case when the missing request asks for offset 7. The bench provokes this with fetches at offsets 7 and 0 of fresh lines. A hit's update of the replacement order can also land in the cycle just before a miss picks its victim. The bench provokes this by touching the oldest line right before a conflicting miss, and it judges the result by whether a later fetch to that line makes a new hub burst. A behavioural model with a queue-based recency list runs beside the design, and the two are compared on every cycle. Ignored fetches during a fill and stray hub pulses while idle are included in the stimulus.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic {
    SRC_LOCAL = 1'b0,
    SRC_CACHE = 1'b1
  } fetch_src_e;
endpackage

// File: rtl/icache_tag_lru.sv
module icache_tag_lru #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 13,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lookup_tag,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  input  logic             inval_en,
  input  logic [WAY_W-1:0] inval_way,
  input  logic             commit_en,
  input  logic [WAY_W-1:0] commit_way,
  input  logic [TAG_W-1:0] commit_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAY_W-1:0] victim_way
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [TAG_W-1:0] tag_q   [WAYS];
  logic [WAY_W-1:0] age_q   [WAYS];
  logic [WAYS-1:0]  valid_q;

  // recency rank after a touch: touched way becomes 0, younger ones age
  function automatic logic [WAY_W-1:0] next_age(input logic [WAY_W-1:0] cur,
                                                input logic [WAY_W-1:0] ref_age,
                                                input logic             touched);
    if (touched)            return '0;
    else if (cur < ref_age) return cur + 1'b1;
    else                    return cur;
  endfunction

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign hit_vec[g] = valid_q[g] && (tag_q[g] == lookup_tag);
    end
  endgenerate

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) hit_way = WAY_W'(i);
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !valid_q[i]) begin
        victim_way = WAY_W'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < WAYS; i++) begin
        if (age_q[i] == OLDEST) victim_way = WAY_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < WAYS; i++) begin
        tag_q[i] <= '0;
        age_q[i] <= WAY_W'(i);
      end
    end else begin
      if (inval_en)  valid_q[inval_way] <= 1'b0;
      if (commit_en) begin
        valid_q[commit_way] <= 1'b1;
        tag_q[commit_way]   <= commit_tag;
      end
      if (touch_en) begin
        for (int i = 0; i < WAYS; i++) begin
          age_q[i] <= next_age(age_q[i], age_q[touch_way], touch_way == WAY_W'(i));
        end
      end
    end
  end
endmodule

// File: rtl/icache_line_store.sv
module icache_line_store #(
  parameter int WAYS       = 4,
  parameter int LINE_LONGS = 8,
  parameter int DATA_W     = 32,
  parameter int WAY_W      = $clog2(WAYS),
  parameter int OFF_W      = $clog2(LINE_LONGS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] way_rd [WAYS];

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_way
      logic [DATA_W-1:0] row_q [LINE_LONGS];
      always_ff @(posedge clk) begin
        if (wr_en && wr_way == WAY_W'(g)) row_q[wr_off] <= wr_data;
      end
      assign way_rd[g] = row_q[rd_off];
    end
  endgenerate

  assign rd_data = way_rd[rd_way];
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl #(
  parameter int PC_W       = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_LONGS = 8,
  parameter int WAY_W      = 2,
  parameter int OFF_W      = $clog2(LINE_LONGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PC_W-1:0]   start_pc,
  input  logic [WAY_W-1:0]  start_way,
  input  logic              hub_rvalid,
  input  logic [DATA_W-1:0] hub_rdata,
  output logic              busy,
  output logic [PC_W-1:0]   miss_pc,
  output logic [WAY_W-1:0]  fill_way,
  output logic [OFF_W-1:0]  beat_idx,
  output logic              beat_we,
  output logic              fill_done,
  output logic [DATA_W-1:0] req_word
);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_LONGS - 1);

  logic              busy_q;
  logic [PC_W-1:0]   pc_q;
  logic [WAY_W-1:0]  way_q;
  logic [OFF_W-1:0]  cnt_q;
  logic [DATA_W-1:0] pend_q;
  logic [OFF_W-1:0]  req_off;

  assign req_off   = pc_q[OFF_W-1:0];
  assign busy      = busy_q;
  assign miss_pc   = pc_q;
  assign fill_way  = way_q;
  assign beat_idx  = cnt_q;
  assign beat_we   = busy_q && hub_rvalid;
  assign fill_done = beat_we && (cnt_q == LAST_BEAT);
  assign req_word  = (cnt_q == req_off) ? hub_rdata : pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pc_q   <= '0;
      way_q  <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        pc_q   <= start_pc;
        way_q  <= start_way;
        cnt_q  <= '0;
      end
    end else if (beat_we) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == req_off) pend_q <= hub_rdata;
      if (fill_done)        busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hubexec_icache.sv
module hubexec_icache
  import icache_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_LONGS = 8,
  parameter int WAYS       = 4,
  parameter int LOCAL_TOP  = 511,
  parameter int LOCAL_AW   = $clog2(LOCAL_TOP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_req,
  input  logic [PC_W-1:0]     fetch_pc,
  output logic                busy,
  output logic                local_rd_en,
  output logic [LOCAL_AW-1:0] local_addr,
  input  logic [DATA_W-1:0]   local_rdata,
  output logic                insn_valid,
  output logic [DATA_W-1:0]   insn_data,
  output logic                hub_req,
  output logic [PC_W-1:0]     hub_addr,
  input  logic                hub_rvalid,
  input  logic [DATA_W-1:0]   hub_rdata
);
  localparam int OFF_W = $clog2(LINE_LONGS);
  localparam int TAG_W = PC_W - OFF_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [PC_W-1:0] LOCAL_LIM = PC_W'(LOCAL_TOP);

  function automatic logic in_local(input logic [PC_W-1:0] pc);
    return pc <= LOCAL_LIM;
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return pc[PC_W-1:OFF_W];
  endfunction
  function automatic logic [OFF_W-1:0] off_of(input logic [PC_W-1:0] pc);
    return pc[OFF_W-1:0];
  endfunction
  function automatic logic [PC_W-1:0] line_base(input logic [PC_W-1:0] pc);
    return {pc[PC_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  // named internal events (observed by the bound checker)
  logic              accept;
  logic              accept_local;
  logic              accept_hit;
  logic              miss_start;
  logic              fill_done;
  logic              hit;
  logic [WAYS-1:0]   hit_vec;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  victim_way;
  logic [PC_W-1:0]   miss_pc;
  logic [WAY_W-1:0]  fill_way;
  logic [OFF_W-1:0]  beat_idx;
  logic              beat_we;
  logic [DATA_W-1:0] req_word;
  logic [DATA_W-1:0] line_rd;
  logic              fill_busy;

  logic              out_valid_q;
  fetch_src_e        out_src_q;
  logic [DATA_W-1:0] out_word_q;

  assign accept       = fetch_req && !fill_busy;
  assign accept_local = accept && in_local(fetch_pc);
  assign accept_hit   = accept && !in_local(fetch_pc) && hit;
  assign miss_start   = accept && !in_local(fetch_pc) && !hit;

  icache_tag_lru #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookup_tag (tag_of(fetch_pc)),
    .touch_en   (accept_hit || fill_done),
    .touch_way  (fill_done ? fill_way : hit_way),
    .inval_en   (miss_start),
    .inval_way  (victim_way),
    .commit_en  (fill_done),
    .commit_way (fill_way),
    .commit_tag (tag_of(miss_pc)),
    .hit        (hit),
    .hit_way    (hit_way),
    .hit_vec    (hit_vec),
    .victim_way (victim_way)
  );

  icache_line_store #(.WAYS(WAYS), .LINE_LONGS(LINE_LONGS), .DATA_W(DATA_W),
                      .WAY_W(WAY_W), .OFF_W(OFF_W)) u_lines (
    .clk     (clk),
    .wr_en   (beat_we),
    .wr_way  (fill_way),
    .wr_off  (beat_idx),
    .wr_data (hub_rdata),
    .rd_way  (hit_way),
    .rd_off  (off_of(fetch_pc)),
    .rd_data (line_rd)
  );

  icache_fill_ctrl #(.PC_W(PC_W), .DATA_W(DATA_W), .LINE_LONGS(LINE_LONGS),
                     .WAY_W(WAY_W), .OFF_W(OFF_W)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (miss_start),
    .start_pc   (fetch_pc),
    .start_way  (victim_way),
    .hub_rvalid (hub_rvalid),
    .hub_rdata  (hub_rdata),
    .busy       (fill_busy),
    .miss_pc    (miss_pc),
    .fill_way   (fill_way),
    .beat_idx   (beat_idx),
    .beat_we    (beat_we),
    .fill_done  (fill_done),
    .req_word   (req_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_src_q   <= SRC_LOCAL;
      out_word_q  <= '0;
    end else begin
      out_valid_q <= accept_local || accept_hit || fill_done;
      out_src_q   <= accept_local ? SRC_LOCAL : SRC_CACHE;
      if (fill_done)       out_word_q <= req_word;
      else if (accept_hit) out_word_q <= line_rd;
    end
  end

  assign busy        = fill_busy;
  assign hub_req     = fill_busy;
  assign hub_addr    = line_base(miss_pc);
  assign local_rd_en = accept_local;
  assign local_addr  = fetch_pc[LOCAL_AW-1:0];
  assign insn_valid  = out_valid_q;
  assign insn_data   = !out_valid_q ? '0 :
                       (out_src_q == SRC_LOCAL) ? local_rdata : out_word_q;
endmodule

// File: rtl/icache_chk.sv
module icache_chk #(
  parameter int PC_W = 16,
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            hub_req,
  input logic [PC_W-1:0] hub_addr,
  input logic            insn_valid,
  input logic            local_rd_en,
  input logic            accept_hit,
  input logic            accept_local,
  input logic            fill_done,
  input logic [WAYS-1:0] hit_vec
);
  // R2
  hub_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_req && !fill_done) |=> (hub_req && $stable(hub_addr)));

  // R5
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!local_rd_en && !accept_hit));

  // R3
  fill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (!busy && !hub_req && insn_valid));

  // R1
  local_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_rd_en |=> (insn_valid && !hub_req));

  // R4
  out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |-> $past(accept_hit || accept_local || fill_done));

  // R7
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

bind hubexec_icache icache_chk #(.PC_W(PC_W), .WAYS(WAYS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .hub_req      (hub_req),
  .hub_addr     (hub_addr),
  .insn_valid   (insn_valid),
  .local_rd_en  (local_rd_en),
  .accept_hit   (accept_hit),
  .accept_local (accept_local),
  .fill_done    (fill_done),
  .hit_vec      (hit_vec)
);

// File: tb/hubexec_icache_bench.sv
`timescale 1ns/1ps
module hubexec_icache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic        busy, local_rd_en, insn_valid, hub_req;
  logic [8:0]  local_addr;
  logic [31:0] local_rdata = '0;
  logic [31:0] insn_data;
  logic [15:0] hub_addr;
  logic        hub_rvalid = 1'b0;
  logic [31:0] hub_rdata = '0;

  always #5 clk = ~clk;

  hubexec_icache u_hubexec_icache (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .busy(busy), .local_rd_en(local_rd_en), .local_addr(local_addr),
    .local_rdata(local_rdata), .insn_valid(insn_valid), .insn_data(insn_data),
    .hub_req(hub_req), .hub_addr(hub_addr), .hub_rvalid(hub_rvalid),
    .hub_rdata(hub_rdata)
  );

  function automatic logic [31:0] localfn(input logic [8:0] a);
    return 32'h1100_0000 + {23'd0, a} * 32'h0001_0003;
  endfunction
  function automatic logic [31:0] hubfn(input logic [15:0] a);
    return {a, ~a} ^ 32'h5A5A_0F0F;
  endfunction

  // local register RAM: one-cycle registered read
  always_ff @(posedge clk) if (local_rd_en) local_rdata <= localfn(local_addr);

  int vectors = 0, fails = 0, bursts = 0;
  bit finished = 0, prev_hreq = 0;
  logic [31:0] seed = 32'h1234_5678;

  // reference model state
  bit          mvalid [4];
  logic [12:0] mtag   [4];
  logic [31:0] mdata  [4][8];
  int          rec[$];          // front = least recently used
  bit          mbusy;
  int          mcnt, mv;
  logic [15:0] mpc;
  bit          mout_v;
  logic [31:0] mout_w;
  string       mout_r;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic touch(input int w);
    foreach (rec[i]) if (rec[i] == w) begin rec.delete(i); break; end
    rec.push_back(w);
  endtask

  task automatic model_reset();
    foreach (mvalid[i]) mvalid[i] = 0;
    rec = {3, 2, 1, 0};
    mbusy = 0; mcnt = 0; mv = 0; mpc = '0;
    mout_v = 0; mout_w = '0; mout_r = "R6";
  endtask

  task automatic step(input logic r, input logic [15:0] p);
    bit nv; logic [31:0] nw; string nr; int hitw, vic;
    bit exp_loc;
    fetch_req = r; fetch_pc = p;
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    if (mbusy) begin
      hub_rvalid = (seed[1:0] != 2'b00);
      hub_rdata  = hubfn((mpc & 16'hFFF8) + 16'(mcnt));
    end else begin
      hub_rvalid = (seed[2:0] == 3'b000);   // stray pulse, must be ignored
      hub_rdata  = 32'hDEAD_BEEF;
    end
    #1;
    exp_loc = !mbusy && r && (p <= 16'h01FF);
    check(busy == mbusy, "R5", "busy", 32'(busy), 32'(mbusy));
    check(hub_req == mbusy, "R2", "hub_req", 32'(hub_req), 32'(mbusy));
    if (mbusy) check(hub_addr == (mpc & 16'hFFF8), "R2", "hub_addr",
                     32'(hub_addr), 32'(mpc & 16'hFFF8));
    check(local_rd_en == exp_loc, mbusy ? "R5" : "R1", "local_rd_en",
          32'(local_rd_en), 32'(exp_loc));
    if (exp_loc) check(local_addr == p[8:0], "R1", "local_addr",
                       32'(local_addr), 32'(p[8:0]));
    check(insn_valid == mout_v, mout_r, "insn_valid", 32'(insn_valid), 32'(mout_v));
    if (mout_v) check(insn_data == mout_w, mout_r, "insn_data", insn_data, mout_w);
    if (hub_req && !prev_hreq) bursts++;
    prev_hreq = hub_req;
    // model transition at the coming edge
    nv = 0; nw = '0; nr = "R6";
    if (mbusy) begin
      if (hub_rvalid) begin
        mdata[mv][mcnt] = hub_rdata;
        mcnt++;
        if (mcnt == 8) begin
          mbusy = 0; mvalid[mv] = 1; mtag[mv] = mpc[15:3]; touch(mv);
          nv = 1; nw = mdata[mv][mpc[2:0]]; nr = "R3";
        end
      end
    end else if (r) begin
      if (p <= 16'h01FF) begin
        nv = 1; nw = localfn(p[8:0]); nr = "R1";
      end else begin
        hitw = -1;
        for (int i = 0; i < 4; i++) if (mvalid[i] && mtag[i] == p[15:3]) hitw = i;
        if (hitw >= 0) begin
          nv = 1; nw = mdata[hitw][p[2:0]]; nr = "R4"; touch(hitw);
        end else begin
          vic = -1;
          for (int i = 0; i < 4; i++) if (vic < 0 && !mvalid[i]) vic = i;
          if (vic < 0) vic = rec[0];
          mvalid[vic] = 0; mbusy = 1; mcnt = 0; mpc = p; mv = vic;
        end
      end
    end
    mout_v = nv; mout_w = nw; mout_r = nr;
    @(negedge clk);
  endtask

  task automatic run_fetch(input logic [15:0] p);
    step(1'b1, p);
    while (mbusy) step(1'b0, 16'h0);
    step(1'b0, 16'h0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    // R6: idle outputs under reset
    check(insn_valid == 0 && hub_req == 0 && busy == 0, "R6", "reset outputs",
          {29'd0, insn_valid, hub_req, busy}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 and R9: first cached fetch misses, neighbour in same line hits
    run_fetch(16'h0200);
    check(bursts == 1, "R6", "bursts after first cached fetch", bursts, 1);
    run_fetch(16'h0207);
    check(bursts == 1, "R9", "bursts after same-line fetch", bursts, 1);

    // R7: fill all four lines, touch the oldest, then conflict
    run_fetch(16'h020F);   // offset 7 of a fresh line: last beat is the word
    run_fetch(16'h0210);
    run_fetch(16'h0218);
    check(bursts == 4, "R7", "bursts after four fills", bursts, 4);
    step(1'b1, 16'h0203);  // hit on oldest line, then miss right after
    run_fetch(16'h0220);
    check(bursts == 5, "R7", "bursts after conflict miss", bursts, 5);
    run_fetch(16'h0201);
    check(bursts == 5, "R7", "touched line survived", bursts, 5);
    run_fetch(16'h020C);
    check(bursts == 6, "R7", "lru line was evicted", bursts, 6);

    // R8: alternate local and cached fetches back to back
    step(1'b1, 16'h0010); step(1'b1, 16'h0204); step(1'b1, 16'h0011);
    step(1'b1, 16'h0222); step(1'b1, 16'h01FF); step(1'b0, 16'h0);
    check(bursts == 6, "R8", "no bursts for resident mix", bursts, 6);

    // R5: local request during a fill is ignored
    step(1'b1, 16'h0300);
    step(1'b1, 16'h0005);
    check(local_rd_en == 0, "R5", "local strobe while busy", 32'(local_rd_en), 0);
    while (mbusy) step(1'b1, 16'h0006);
    step(1'b0, 16'h0);

    // mixed traffic
    for (int n = 0; n < 6000; n++) begin
      logic [15:0] pc;
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      pc = (seed[5:4] == 2'b00) ? {7'd0, seed[16:8]} : (16'h0200 + {8'd0, seed[23:16]});
      step(seed[31:29] != 3'b000, pc);
    end
    while (mbusy) step(1'b0, 16'h0);
    step(1'b0, 16'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule